// File: doc/BRIEF.md
# Machine-Cycle Beat Generator with Run and Bus Yield Control

This block produces the beat signals that a hardwired control unit uses to sequence each machine cycle. A ring of flip-flops holds a single active beat that moves from T0 to T1, T2 and T3 on successive clocks and then wraps back to T0. The control unit decodes its control signals from these beats, which is outside this block.

The ring can only stop at a cycle boundary, after T3. When the control unit raises its end-of-instruction strobe while the run input is low, the current sequence finishes and then all beats go low. A later run request restarts the ring at T0. A DMA request is acted on only at the same boundary. Instead of starting a new sequence, the block blanks the beats and raises a bus-grant output until the request is withdrawn. The ring then starts again at T0. While the memory-ready input is low, the third beat (T2) repeats to add wait states.

Top module: `machine_beat_gen`

## Requirements
- R1: While reset is asserted (rst_n low), `beat` equals 4'b0001 (only T0 active, bit i being beat Ti) and `bus_grant` is low.
- R2: While running with `mem_ready` high and no boundary action, the active beat moves one position per clock: T0, T1, T2, T3, then T0 again.
- R3: While running, exactly one bit of `beat` is high. While halted or while the bus is granted, all bits of `beat` are low.
- R4: While T2 is active, each clock edge that samples `mem_ready` low keeps T2 active. The first edge that samples it high moves the ring to T3.
- R5: If `end_strobe` is sampled high with `run_en` low during any beat of a sequence, the sequence still runs through T3. On the clock after T3, all beats go low (halted).
- R6: While halted, an edge that samples `run_en` high and `dma_req` low makes T0 the only active beat.
- R7: A `dma_req` sampled high at T3 blanks all beats and raises `bus_grant` on the next clock. If `dma_req` is high at T0, T1 or T2, the ring keeps moving.
- R8: While the bus is granted, the first edge that samples `dma_req` low clears `bus_grant` and makes T0 active.
- R9: At a T3 boundary where both a DMA request and a stop are pending, the DMA request wins. The pending stop is discarded, so the ring restarts at T0 after the grant ends.
- R10: `end_strobe` has no effect while `run_en` is high, or while the block is halted or granted.
- R11: While halted, a `dma_req` sampled high raises `bus_grant` on the next clock, and the beats stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; beats change on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run permission; low together with end_strobe requests a stop |
| end_strobe | input | 1 | End-of-instruction strobe from the control unit |
| dma_req | input | 1 | Bus request from a DMA master, held until served |
| mem_ready | input | 1 | Memory ready; low stretches T2 |
| beat | output | 4 | One-hot beat vector, bit i is Ti |
| bus_grant | output | 1 | High while the bus is yielded to DMA |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable around the rising edge. They also assume that a DMA master keeps `dma_req` high until it sees `bus_grant`, since the block acts on the request only at a boundary. The bench drives every input at the falling edge. It steps DMA requests, stops and wait states across every beat position. It then runs a long pseudo-random sweep, and a cycle model computes the expected beats for each clock.

// File: rtl/beat_pkg.sv
package beat_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_HALT  = 2'd1,
    MODE_GRANT = 2'd2
  } beat_mode_e;

  // Index of the ring position that feeds position idx on a step.
  function automatic int unsigned feeder_index(input int unsigned idx,
                                               input int unsigned n);
    return (idx + n - 1) % n;
  endfunction

endpackage

// File: rtl/beat_ring.sv
module beat_ring #(
  parameter int unsigned NUM_BEATS = 4,
  parameter int unsigned WAIT_BEAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 restart,
  input  logic                 blank,
  output logic [NUM_BEATS-1:0] beat_o,
  output logic                 at_wait,
  output logic                 at_last
);
  import beat_pkg::*;

  localparam int unsigned LAST_BEAT = NUM_BEATS - 1;

  logic [NUM_BEATS-1:0] ring_q;

  for (genvar i = 0; i < NUM_BEATS; i++) begin : g_stage
    localparam int unsigned SRC = feeder_index(i, NUM_BEATS);
    localparam logic RST_VAL = (i == 0);
    logic nxt;
    always_comb begin
      if (blank)        nxt = 1'b0;
      else if (restart) nxt = RST_VAL;
      else if (step)    nxt = ring_q[SRC];
      else              nxt = ring_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ring_q[i] <= RST_VAL;
      else        ring_q[i] <= nxt;
    end
  end

  assign beat_o  = ring_q;
  assign at_wait = ring_q[WAIT_BEAT];
  assign at_last = ring_q[LAST_BEAT];

  // R3
  ring_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ring_q))
    else $error("ring holds more than one beat");

endmodule

// File: rtl/beat_run_ctrl.sv
module beat_run_ctrl (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               end_i,
  input  logic               dma_req_i,
  input  logic               mem_ready_i,
  input  logic               at_wait,
  input  logic               at_last,
  output logic               step,
  output logic               restart,
  output logic               blank,
  output beat_pkg::beat_mode_e mode_o
);
  import beat_pkg::*;

  beat_mode_e mode_q, mode_d;
  logic       stop_q, stop_d;

  // Named internal events
  logic running, halted, granted;
  logic stop_req;     // end seen with run low in this cycle
  logic stop_now;     // a stop is pending for this sequence
  logic wait_hold;    // T2 stretched by memory
  logic boundary;     // T3 active, sequence ends on this edge
  logic take_bus;     // yield at boundary or from halt
  logic take_stop;    // halt at boundary

  assign running   = (mode_q == MODE_RUN);
  assign halted    = (mode_q == MODE_HALT);
  assign granted   = (mode_q == MODE_GRANT);
  assign stop_req  = running && end_i && !run_i;
  assign stop_now  = stop_q || stop_req;
  assign wait_hold = running && at_wait && !mem_ready_i;
  assign boundary  = running && at_last;
  assign take_bus  = (boundary || halted) && dma_req_i;
  assign take_stop = boundary && !dma_req_i && stop_now;

  always_comb begin
    mode_d = mode_q;
    stop_d = stop_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (boundary) begin
          stop_d = 1'b0;
          if (take_bus)       mode_d = MODE_GRANT;
          else if (take_stop) mode_d = MODE_HALT;
        end else begin
          stop_d = stop_now;
        end
      end
      MODE_HALT: begin
        if (dma_req_i)  mode_d = MODE_GRANT;
        else if (run_i) mode_d = MODE_RUN;
      end
      MODE_GRANT: begin
        if (!dma_req_i) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      stop_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      stop_q <= stop_d;
    end
  end

  assign step    = running && !wait_hold;
  assign blank   = take_bus || take_stop;
  assign restart = (halted && !dma_req_i && run_i) || (granted && !dma_req_i);
  assign mode_o  = mode_q;

  // R4
  wait_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && at_wait && !mem_ready_i) |=> at_wait)
    else $error("T2 did not repeat while memory busy");

  // R2
  no_early_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !at_last && !at_wait) |=> !at_wait || !at_last)
    else $error("ring jumped");

endmodule

// File: rtl/machine_beat_gen.sv
module machine_beat_gen #(
  parameter int unsigned NUM_BEATS = 4,
  parameter int unsigned WAIT_BEAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 end_strobe,
  input  logic                 dma_req,
  input  logic                 mem_ready,
  output logic [NUM_BEATS-1:0] beat,
  output logic                 bus_grant
);
  import beat_pkg::*;

  logic       step, restart, blank, at_wait, at_last;
  beat_mode_e mode;

  beat_run_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_en),
    .end_i       (end_strobe),
    .dma_req_i   (dma_req),
    .mem_ready_i (mem_ready),
    .at_wait     (at_wait),
    .at_last     (at_last),
    .step        (step),
    .restart     (restart),
    .blank       (blank),
    .mode_o      (mode)
  );

  beat_ring #(
    .NUM_BEATS (NUM_BEATS),
    .WAIT_BEAT (WAIT_BEAT)
  ) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .restart (restart),
    .blank   (blank),
    .beat_o  (beat),
    .at_wait (at_wait),
    .at_last (at_last)
  );

  assign bus_grant = (mode == MODE_GRANT);

  // Named events for the checks
  logic is_running, is_halted;
  assign is_running = (mode == MODE_RUN);
  assign is_halted  = (mode == MODE_HALT);

  // R3
  run_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_running |-> $onehot(beat))
    else $error("running without exactly one beat");

  // R3
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_running |-> (beat == '0))
    else $error("beat active while idle");

  // R7
  dma_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_running && at_last && dma_req) |=> (bus_grant && beat == '0))
    else $error("DMA not granted at boundary");

  // R8
  dma_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !dma_req) |=> (!bus_grant && beat[0]))
    else $error("no restart at T0 after grant");

  // R6
  halt_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_halted && run_en && !dma_req) |=> beat[0])
    else $error("no restart at T0 after halt");

  // R11
  halt_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_halted && dma_req) |=> bus_grant)
    else $error("DMA not granted from halt");

endmodule

// File: tb/machine_beat_gen_test.sv
`timescale 1ns/1ps
module machine_beat_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b1;
  logic       end_strobe = 1'b0;
  logic       dma_req = 1'b0;
  logic       mem_ready = 1'b1;
  logic [3:0] beat;
  logic       bus_grant;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R2";
  bit done = 1'b0;

  always #4 clk = ~clk;

  machine_beat_gen uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .end_strobe(end_strobe),
    .dma_req(dma_req), .mem_ready(mem_ready), .beat(beat), .bus_grant(bus_grant)
  );

  // Cycle model: m_mode 0 run, 1 halt, 2 granted
  int m_mode = 0;
  int m_idx  = 0;
  bit m_stop = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 0; m_idx <= 0; m_stop <= 1'b0;
    end else begin
      case (m_mode)
        0: begin
          if (m_idx == 3) begin
            m_stop <= 1'b0;
            if (dma_req) m_mode <= 2;
            else if (m_stop || (end_strobe && !run_en)) m_mode <= 1;
            else m_idx <= 0;
          end else begin
            if (end_strobe && !run_en) m_stop <= 1'b1;
            if (!(m_idx == 2 && !mem_ready)) m_idx <= m_idx + 1;
          end
        end
        1: begin
          if (dma_req) m_mode <= 2;
          else if (run_en) begin m_mode <= 0; m_idx <= 0; end
        end
        default: begin
          if (!dma_req) begin m_mode <= 0; m_idx <= 0; end
        end
      endcase
    end
  end

  function automatic logic [3:0] expect_beat(int mode, int idx);
    return (mode == 0) ? 4'(1 << idx) : 4'b0000;
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: beat/grant actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_tag, {bus_grant, beat}, {m_mode == 2, expect_beat(m_mode, m_idx)});
      checks++;
      if (m_mode == 0 ? ($countones(beat) != 1) : (beat != 4'b0000)) begin
        errors++;
        $display("FAIL R3: beat actual %b expected %s", beat,
                 m_mode == 0 ? "one-hot" : "0000");
      end
    end
  end

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_beat(int k);
    while (!(m_mode == 0 && m_idx == k)) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    cyc(2);
    // R1: reset state
    check("R1", {bus_grant, beat}, 5'b0_0001);
    cyc(1);
    check("R1", {bus_grant, beat}, 5'b0_0001);
    rst_n = 1'b1;

    cur_tag = "R2"; cyc(10);

    // R4: wait states of several lengths
    cur_tag = "R4";
    for (int w = 1; w <= 5; w++) begin
      wait_beat(1);
      mem_ready = 1'b0;
      cyc(1 + w);
      mem_ready = 1'b1;
      cyc(3);
    end

    // R5 and R6: stop requested at each beat, then resume
    for (int k = 0; k < 4; k++) begin
      cur_tag = "R5";
      wait_beat(k);
      run_en = 1'b0; end_strobe = 1'b1;
      cyc(1);
      end_strobe = 1'b0;
      cyc(6);
      cur_tag = "R10";
      end_strobe = 1'b1; cyc(2); end_strobe = 1'b0;
      cur_tag = "R6";
      run_en = 1'b1;
      cyc(4);
    end

    // R10: end strobe with run high
    cur_tag = "R10";
    end_strobe = 1'b1; cyc(9); end_strobe = 1'b0; cyc(2);

    // R7 and R8: DMA raised at each beat
    for (int k = 0; k < 4; k++) begin
      cur_tag = "R7";
      wait_beat(k);
      dma_req = 1'b1;
      cyc(6);
      cur_tag = "R10";
      end_strobe = 1'b1; run_en = 1'b0; cyc(1);
      end_strobe = 1'b0; run_en = 1'b1;
      cur_tag = "R8";
      dma_req = 1'b0;
      cyc(3);
    end

    // R9: stop and DMA both pending at the boundary
    cur_tag = "R9";
    wait_beat(1);
    run_en = 1'b0; end_strobe = 1'b1; cyc(1); end_strobe = 1'b0;
    dma_req = 1'b1; cyc(5);
    dma_req = 1'b0; cyc(6);
    run_en = 1'b1; cyc(2);

    // R11: DMA while halted
    cur_tag = "R11";
    wait_beat(0);
    run_en = 1'b0; end_strobe = 1'b1; cyc(1); end_strobe = 1'b0;
    cyc(5);
    dma_req = 1'b1; cyc(3);
    dma_req = 1'b0; run_en = 1'b1; cyc(4);

    // Pseudo-random sweep over all input combinations
    cur_tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_en     = (lfsr[3:0] != 4'd0);
      end_strobe = lfsr[5] & lfsr[6];
      mem_ready  = (lfsr[13:12] != 2'd0);
      if (lfsr[11:8] == 4'd0) dma_req = !dma_req;
      cyc(1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule